// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a single level input that software is expected to toggle at regular intervals. Each change of level, whether up or down, restarts an internal down-window. If the window runs out with no change, the block raises a strobe for exactly one clock. A reset generator consumes this strobe and starts a reset pulse.

The kick input is asynchronous. It passes through a two-flop synchronizer, and an edge detector then compares the synchronized level with its previous value. While the reset generator reports that reset is active, or while the system runs from its backup supply, the counter stays at zero. Counting starts again on the first clock after both of those conditions drop.

No input can switch the timer off. A kick input that stays at one level therefore produces a strobe once per window, for as long as nothing holds the counter. The window length comes from the clock rate in kHz multiplied by the timeout in ms. The defaults give a 1.6 s window at 1 MHz.

Top module: `wdt_edge_watchdog`

## Requirements
- R1: `timeout_pulse` is never high on two consecutive clocks.
- R2: With no kick and no hold, `timeout_pulse` rises exactly TIMEOUT_CYCLES = CLK_KHZ*TIMEOUT_MS clock edges after the last edge that cleared the counter.
- R3: A low-to-high change on `kick_in` clears the counter on the third rising clock edge after the change: two edges for the synchronizer and one for the edge register.
- R4: A high-to-low change on `kick_in` clears the counter with the same three-edge latency as R3.
- R5: While `reset_active` is sampled high, the counter is held at zero and no strobe fires. The first edge that samples it low counts 1.
- R6: While `backup_mode` is sampled high, the timer behaves as under R5.
- R7: Changes on `kick_in` while the counter is held add no delay to the window that starts after the hold releases.
- R8: When the input stays at one level and no hold occurs, the strobe recurs every TIMEOUT_CYCLES edges, because the counter clears on the edge that fires the strobe.
- R9: If a kick's clearing edge is the edge on which the window would expire, no strobe fires and a new full window starts.
- R10: If a hold is first sampled on the expiry edge, no strobe fires.
- R11: While `rst` is high, `timeout_pulse` is 0 and the synchronizer, edge register and counter clear. The window then counts from the first edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| kick_in | input | 1 | Asynchronous watchdog input; either edge restarts the window |
| reset_active | input | 1 | High while the reset generator holds reset |
| backup_mode | input | 1 | High while running from the backup supply |
| timeout_pulse | output | 1 | One-clock strobe when the window expires |

## Verification
The assertions assume that `reset_active` and `backup_mode` are synchronous to `clk`. They also assume that any change on `kick_in` settles before the synchronizer samples it. The bench therefore drives every input one time step after a falling clock edge. Because of the three-edge kick latency, the bench does not release a hold until at least four clocks after the last kick given during that hold. For the same reason, it places kicks either at least four clocks before a pending expiry or exactly three clocks before it. Those are the only spacings whose outcome R3 and R9 fix in advance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Window length in clock cycles from clock rate (kHz) and timeout (ms).
    function automatic longint unsigned window_cycles(input int unsigned clk_khz,
                                                      input int unsigned timeout_ms);
        return longint'(clk_khz) * longint'(timeout_ms);
    endfunction

    localparam int unsigned SYNC_DEPTH = 2;

    // Synchronized kick level together with its change flag.
    typedef struct packed {
        logic level;
        logic toggled;
    } kick_t;

    // What the counter does on the coming edge.
    typedef enum logic [1:0] {
        PH_HELD   = 2'd0,
        PH_RUN    = 2'd1,
        PH_KICKED = 2'd2,
        PH_EXPIRE = 2'd3
    } phase_e;

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/wdt_edge_detect.sv
module wdt_edge_detect
    import wdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level_in,
    output kick_t kick
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_in;
    end

    always_comb begin
        kick.level   = level_in;
        kick.toggled = level_in ^ prev_q;
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             kick,
    output logic [CNT_W-1:0] count,
    output logic             strobe
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    phase_e           phase;
    logic [CNT_W-1:0] count_q;
    logic             strobe_q;

    always_comb begin
        if (hold)                 phase = PH_HELD;
        else if (kick)            phase = PH_KICKED;
        else if (count_q == LAST) phase = PH_EXPIRE;
        else                      phase = PH_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            strobe_q <= 1'b0;
        end else begin
            unique case (phase)
                PH_HELD, PH_KICKED: begin
                    count_q  <= '0;
                    strobe_q <= 1'b0;
                end
                PH_EXPIRE: begin
                    count_q  <= '0;
                    strobe_q <= 1'b1;
                end
                default: begin
                    count_q  <= count_q + 1'b1;
                    strobe_q <= 1'b0;
                end
            endcase
        end
    end

    assign count  = count_q;
    assign strobe = strobe_q;
endmodule

// File: rtl/wdt_edge_watchdog.sv
module wdt_edge_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_KHZ    = 1000,
    parameter int unsigned TIMEOUT_MS = 1600
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_in,
    input  logic reset_active,
    input  logic backup_mode,
    output logic timeout_pulse
);
    localparam int unsigned TIMEOUT_CYCLES = int'(window_cycles(CLK_KHZ, TIMEOUT_MS));
    localparam int unsigned CNT_W          = $clog2(TIMEOUT_CYCLES + 1);

    logic             kick_sync;
    kick_t            kick_info;
    logic             kick_edge;
    logic             hold;
    logic [CNT_W-1:0] count_q;

    wdt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (kick_in),
        .dout (kick_sync)
    );

    wdt_edge_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (kick_sync),
        .kick     (kick_info)
    );

    assign kick_edge = kick_info.toggled;
    assign hold      = reset_active | backup_mode;

    wdt_counter #(.LIMIT(TIMEOUT_CYCLES), .CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .kick   (kick_edge),
        .count  (count_q),
        .strobe (timeout_pulse)
    );
endmodule

// File: rtl/wdt_edge_watchdog_checker.sv
module wdt_edge_watchdog_checker #(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             reset_active,
    input logic             backup_mode,
    input logic             kick_edge,
    input logic [CNT_W-1:0] count,
    input logic             timeout_pulse
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |=> !timeout_pulse);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        count < CNT_W'(LIMIT));

    a_r5_hold_clears: assert property (@(posedge clk) disable iff (rst)
        reset_active |=> (count == '0) && !timeout_pulse);

    a_r6_backup_clears: assert property (@(posedge clk) disable iff (rst)
        backup_mode |=> (count == '0) && !timeout_pulse);

    a_r9_kick_wins: assert property (@(posedge clk) disable iff (rst)
        kick_edge |=> !timeout_pulse && (count == '0));

    a_r8_restart_on_fire: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> count == '0);
endmodule

bind wdt_edge_watchdog wdt_edge_watchdog_checker #(
    .LIMIT (TIMEOUT_CYCLES),
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reset_active  (reset_active),
    .backup_mode   (backup_mode),
    .kick_edge     (kick_edge),
    .count         (count_q),
    .timeout_pulse (timeout_pulse)
);

// File: tb/wdt_edge_watchdog_bench.sv
module wdt_edge_watchdog_bench;
    localparam int unsigned CLK_KHZ    = 20;
    localparam int unsigned TIMEOUT_MS = 2;
    localparam int          L          = CLK_KHZ * TIMEOUT_MS;   // 40 cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick_in = 1'b0;
    logic reset_active = 1'b0;
    logic backup_mode = 1'b0;
    logic timeout_pulse;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit held    = 1'b1;     // bench view: counter currently held
    bit done    = 1'b0;
    bit prev_pulse = 1'b0;
    int expq[$];            // expected strobe cycles

    always #2.5 clk = ~clk;   // 200 MHz

    always @(posedge clk) cyc <= cyc + 1;

    wdt_edge_watchdog #(.CLK_KHZ(CLK_KHZ), .TIMEOUT_MS(TIMEOUT_MS)) u_wdt_edge_watchdog (
        .clk           (clk),
        .rst           (rst),
        .kick_in       (kick_in),
        .reset_active  (reset_active),
        .backup_mode   (backup_mode),
        .timeout_pulse (timeout_pulse)
    );

    task automatic fail(input string req, input int act, input int exp);
        errors++;
        $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    endtask

    task automatic flush_after(input int c);
        while (expq.size() > 0 && expq[expq.size()-1] > c) void'(expq.pop_back());
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    // Toggle kick_in; clears on the third edge after the change (R3/R4).
    task automatic kick();
        tick();
        kick_in = ~kick_in;
        if (!held) begin
            flush_after(cyc);
            expq.push_back(cyc + 3 + L);
        end
    endtask

    task automatic update_hold();
        bit now_held;
        now_held = reset_active | backup_mode | rst;
        if (now_held && !held) flush_after(cyc);
        if (!now_held && held) expq.push_back(cyc + L);
        held = now_held;
    endtask

    task automatic set_ra(input logic v);
        tick(); reset_active = v; update_hold();
    endtask

    task automatic set_bm(input logic v);
        tick(); backup_mode = v; update_hold();
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) tick();
    endtask

    // Monitor: compares strobes against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (timeout_pulse) begin
                vectors++;
                if (prev_pulse) fail("R1 width", 2, 1);
                if (expq.size() == 0) fail("R2 unexpected strobe", cyc, -1);
                else if (expq[0] != cyc) begin
                    fail("R2 strobe cycle", cyc, expq[0]);
                    void'(expq.pop_front());
                end else begin
                    void'(expq.pop_front());
                    expq.push_back(cyc + L);   // R8 recurrence
                end
            end else if (expq.size() > 0 && expq[0] < cyc) begin
                vectors++;
                fail("R2 missed strobe", 0, expq[0]);
                void'(expq.pop_front());
            end
            prev_pulse = timeout_pulse;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        int d;
        // R11: reset state
        idle(5);
        vectors++;
        if (timeout_pulse !== 1'b0) fail("R11 reset output", int'(timeout_pulse), 0);
        tick(); rst = 1'b0; update_hold();
        // R2 + R8: stuck low, two recurring strobes
        wait_until(expq[0] + 1 + L);
        // R3/R4: periodic kicks both directions keep it quiet
        for (int i = 0; i < 6; i++) begin
            kick();
            idle(20);
        end
        // R4: falling kick then silence
        if (kick_in == 1'b0) kick();
        idle(10);
        kick();                         // high -> low
        wait_until(expq[0] + 2);
        // R3: rising kick then silence
        kick();                         // low -> high
        wait_until(expq[0] + 2);
        // R5 + R7: long hold via reset_active with kicks inside
        set_ra(1'b1);
        idle(L + 10);
        kick(); idle(7); kick(); idle(6);
        set_ra(1'b0);
        wait_until(expq[0] + 2);
        // R6: hold via backup_mode
        set_bm(1'b1);
        idle(2 * L);
        kick(); idle(6);
        set_bm(1'b0);
        wait_until(expq[0] + 2);
        // R9: kick clear lands on the expiry edge
        d = expq[0];
        wait_until(d - 3);
        kick_in = ~kick_in;
        flush_after(cyc);
        expq.push_back(cyc + 3 + L);
        wait_until(d + 1);
        vectors++;
        if (expq.size() != 1 || expq[0] != d + L)
            fail("R9 suppress", expq.size() > 0 ? expq[0] : -1, d + L);
        wait_until(expq[0] + 2);
        // R10: hold first sampled on expiry edge
        d = expq[0];
        wait_until(d - 1);
        reset_active = 1'b1; update_hold();
        wait_until(d + 3);
        vectors++;
        if (expq.size() != 0) fail("R10 suppress", expq.size(), 0);
        set_ra(1'b0);
        wait_until(expq[0] + 2);
        // finish: hold and confirm nothing pending
        set_bm(1'b1);
        idle(L + 5);
        vectors++;
        if (expq.size() != 0) fail("R5 final hold", expq.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule